// File: doc/BRIEF.md
# Greyscale Frame Scan-Out Expander

The block reads a frame stored as packed 4-bit grey levels, two pixels per byte, and turns it into a magnified stream of colour pixels for a display pipeline. Each stored pixel becomes a MAG x MAG square of output pixels. With the default geometry of 64 source rows of 64 bytes and MAG = 4, one scan produces 256 output lines of 512 pixels each. The grey level is widened by bit replication into one of three colour packings, chosen at the start of each frame.

Frame memory is reached through a synchronous read port with one cycle of latency. Each source row is read once into a local line buffer, and its output lines are then produced from that buffer. Output follows a valid/ready handshake and carries start-of-line and start-of-frame markers. Nothing is scanned until the frame has been marked dirty through the invalidate input. The mark clears when the last pixel of a frame is accepted. An invalidate that arrives while a scan is running queues exactly one more frame.

Top module: `grey_scan_expander`

## Requirements
- R1: During reset and after it, until invalidate is first asserted, pixValid and memRdEn stay low.
- R2: A single-cycle invalidate pulse while idle causes exactly one frame of ROWS*MAG lines of BYTES*2*MAG pixels to be emitted.
- R3: Source byte c of row r is read at address r*BYTES+c. Each row is read once per frame in ascending order, for ROWS*BYTES reads per frame. A read is never issued while pixValid is high.
- R4: Within a byte, the pixel in bits 7:4 is emitted before (left of) the pixel in bits 3:0.
- R5: Each source pixel is repeated MAG times along a line, and each source row yields MAG identical output lines.
- R6: Format codes 2 and 3 give 24-bit pixels in which each 8-bit channel is {g,g}, for grey level g.
- R7: Format code 0 gives n = 2g + (g>>3) in bits 14:10, 9:5 and 4:0, with bits 23:15 zero.
- R8: Format code 1 gives n in bits 15:11 and 4:0, {n, n[4]} in bits 10:5, and zeros in bits 23:16.
- R9: fmtSel is sampled when a frame starts. Changing it during the frame has no effect on that frame's pixels.
- R10: While pixValid is high and pixReady is low, pixValid, pixData, pixSol and pixSof hold their values. No pixel is dropped or repeated.
- R11: pixSol is high exactly on the first pixel of each output line. pixSof is high exactly on the first pixel of the frame and implies pixSol.
- R12: After a frame completes with no invalidate seen during it, no further reads or pixels occur. An invalidate during a scan produces exactly one more frame, using the format present when that frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| invalidate | input | 1 | Marks the frame dirty so that a scan follows |
| fmtSel | input | 2 | Colour packing: 0 = 555, 1 = 565, 2 or 3 = 888 |
| memRdEn | output | 1 | Frame memory read request |
| memAddr | output | $clog2(ROWS*BYTES) | Frame memory byte address |
| memRdData | input | 8 | Read data, valid one cycle after memRdEn |
| pixData | output | 24 | Output pixel, zero-extended for 15/16-bit packings |
| pixValid | output | 1 | Output pixel valid |
| pixSol | output | 1 | First pixel of an output line |
| pixSof | output | 1 | First pixel of the frame |
| pixReady | input | 1 | Downstream accepts the pixel |

## Verification
Counter faults show up quickly at the ports. A misstep in the horizontal repeat, nibble or byte counters breaks the expected pixel at that pixel position, and it usually also moves pixSol within one line. A faulty vertical-repeat or row counter changes the read address sequence at the next fetch and breaks the line-repeat comparison on the next output line. Errors in the dirty or rearm flag become visible only at frame boundaries, as a missing frame or an extra run of reads within a few cycles of the last accepted pixel. A corrupted format register produces a wrong pixel from the very first pixel of the frame.

// File: rtl/gse_pkg.sv
package gse_pkg;
  localparam int PIX_W  = 24;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    FMT_RGB555  = 2'd0,
    FMT_RGB565  = 2'd1,
    FMT_RGB888  = 2'd2,
    FMT_RGB888X = 2'd3
  } pix_fmt_e;

  // strobes from sequencing control into the pixel datapath
  typedef struct packed {
    logic fmtLoad;   // capture the format for a new frame
    logic bufWrite;  // returning read data goes into the line buffer
    logic nibLo;     // select the right-hand (low) nibble
  } gse_strobe_t;
endpackage

// File: rtl/gse_ctrl.sv
module gse_ctrl import gse_pkg::*; #(
  parameter int ROWS   = 64,
  parameter int BYTES  = 64,
  parameter int MAG    = 4,
  parameter int ADDR_W = $clog2(ROWS * BYTES),
  parameter int COL_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              invalidate,
  input  logic              pixReady,
  output logic              pixValid,
  output logic              pixSol,
  output logic              pixSof,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output gse_strobe_t       strobe,
  output logic [COL_W-1:0]  wrIdx,
  output logic [COL_W-1:0]  rdIdx
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int REP_W = (MAG > 1) ? $clog2(MAG) : 1;
  localparam int FC_W  = $clog2(BYTES + 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(BYTES - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(MAG - 1);
  localparam logic [FC_W-1:0]  FC_END   = FC_W'(BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EMIT} st_e;

  st_e              state;
  logic             dirty, rearm;
  logic [FC_W-1:0]  fCnt;
  logic [ROW_W-1:0] srcRow;
  logic [COL_W-1:0] byteIdx;
  logic             nibLo;
  logic [REP_W-1:0] hRep, vRep;
  logic             wrPend;
  logic [COL_W-1:0] wrIdxQ;

  logic accept, lineEnd, rowEnd, frameEnd, startScan;

  assign pixValid  = (state == ST_EMIT);
  assign accept    = pixValid & pixReady;
  assign lineEnd   = (hRep == REP_LAST) && nibLo && (byteIdx == COL_LAST);
  assign rowEnd    = lineEnd && (vRep == REP_LAST);
  assign frameEnd  = accept && rowEnd && (srcRow == ROW_LAST);
  assign startScan = (state == ST_IDLE) && dirty;

  assign memRdEn = (state == ST_FETCH) && (fCnt != FC_END);
  assign memAddr = ADDR_W'(int'(srcRow) * BYTES + int'(fCnt));

  assign pixSol = pixValid && (hRep == '0) && !nibLo && (byteIdx == '0);
  assign pixSof = pixSol && (vRep == '0) && (srcRow == '0);

  assign strobe.fmtLoad  = startScan;
  assign strobe.bufWrite = wrPend;
  assign strobe.nibLo    = nibLo;
  assign wrIdx = wrIdxQ;
  assign rdIdx = byteIdx;

  // dirty mark and one-deep rescan request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty <= 1'b0;
      rearm <= 1'b0;
    end else if (frameEnd) begin
      dirty <= invalidate | rearm;
      rearm <= 1'b0;
    end else begin
      dirty <= dirty | invalidate;
      if (invalidate && state != ST_IDLE) rearm <= 1'b1;
    end
  end

  // read-return pipeline into the line buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPend <= 1'b0;
      wrIdxQ <= '0;
    end else begin
      wrPend <= memRdEn;
      wrIdxQ <= fCnt[COL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fCnt    <= '0;
      srcRow  <= '0;
      byteIdx <= '0;
      nibLo   <= 1'b0;
      hRep    <= '0;
      vRep    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (dirty) begin
            state  <= ST_FETCH;
            srcRow <= '0;
            fCnt   <= '0;
          end
        end
        ST_FETCH: begin
          if (fCnt == FC_END) begin
            state   <= ST_EMIT;
            hRep    <= '0;
            nibLo   <= 1'b0;
            byteIdx <= '0;
            vRep    <= '0;
          end else begin
            fCnt <= fCnt + 1'b1;
          end
        end
        ST_EMIT: begin
          if (accept) begin
            if (hRep != REP_LAST) begin
              hRep <= hRep + 1'b1;
            end else begin
              hRep  <= '0;
              nibLo <= ~nibLo;
              if (nibLo) begin
                if (byteIdx != COL_LAST) begin
                  byteIdx <= byteIdx + 1'b1;
                end else begin
                  byteIdx <= '0;
                  if (vRep != REP_LAST) begin
                    vRep <= vRep + 1'b1;
                  end else begin
                    vRep <= '0;
                    fCnt <= '0;
                    if (srcRow == ROW_LAST) begin
                      state <= ST_IDLE;
                    end else begin
                      srcRow <= srcRow + 1'b1;
                      state  <= ST_FETCH;
                    end
                  end
                end
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gse_datapath.sv
module gse_datapath import gse_pkg::*; #(
  parameter int BYTES = 64,
  parameter int COL_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gse_strobe_t       strobe,
  input  logic [1:0]        fmtSel,
  input  logic [COL_W-1:0]  wrIdx,
  input  logic [COL_W-1:0]  rdIdx,
  input  logic [BYTE_W-1:0] memRdData,
  output logic [PIX_W-1:0]  pixData
);
  logic [BYTE_W-1:0] lineBuf [BYTES];
  pix_fmt_e          fmtReg;
  logic [BYTE_W-1:0] srcByte;
  logic [3:0]        grey;
  logic [4:0]        lvl5;
  logic [5:0]        lvl6;
  logic [7:0]        lvl8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fmtReg <= FMT_RGB888;
    else if (strobe.fmtLoad) fmtReg <= pix_fmt_e'(fmtSel);
  end

  always_ff @(posedge clk) begin
    if (strobe.bufWrite) lineBuf[wrIdx] <= memRdData;
  end

  // grey level widened by replicating its top bits into the new LSBs
  always_comb begin
    srcByte = lineBuf[rdIdx];
    grey    = strobe.nibLo ? srcByte[3:0] : srcByte[7:4];
    lvl5    = {grey, grey[3]};
    lvl6    = {lvl5, lvl5[4]};
    lvl8    = {grey, grey};
    case (fmtReg)
      FMT_RGB555: pixData = {9'd0, lvl5, lvl5, lvl5};
      FMT_RGB565: pixData = {8'd0, lvl5, lvl6, lvl5};
      default:    pixData = {lvl8, lvl8, lvl8};
    endcase
  end
endmodule

// File: rtl/grey_scan_expander.sv
module grey_scan_expander import gse_pkg::*; #(
  parameter int ROWS  = 64,
  parameter int BYTES = 64,
  parameter int MAG   = 4,
  localparam int ADDR_W = $clog2(ROWS * BYTES),
  localparam int COL_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              invalidate,
  input  logic [1:0]        fmtSel,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic [23:0]       pixData,
  output logic              pixValid,
  output logic              pixSol,
  output logic              pixSof,
  input  logic              pixReady
);
  gse_strobe_t      strobe;
  logic [COL_W-1:0] wrIdx, rdIdx;

  gse_ctrl #(
    .ROWS(ROWS), .BYTES(BYTES), .MAG(MAG), .ADDR_W(ADDR_W), .COL_W(COL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .invalidate(invalidate), .pixReady(pixReady),
    .pixValid(pixValid), .pixSol(pixSol), .pixSof(pixSof),
    .memRdEn(memRdEn), .memAddr(memAddr),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  gse_datapath #(
    .BYTES(BYTES), .COL_W(COL_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fmtSel(fmtSel),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .memRdData(memRdData), .pixData(pixData)
  );
endmodule

// File: rtl/gse_checker.sv
module gse_checker #(
  parameter int ADDR_W   = 12,
  parameter int ADDR_MAX = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pixValid,
  input logic              pixReady,
  input logic [23:0]       pixData,
  input logic              pixSol,
  input logic              pixSof,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pixValid && !memRdEn));

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |-> (int'(memAddr) < ADDR_MAX));

  assert_no_fetch_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(memRdEn && pixValid));

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pixValid && !pixReady) |=>
      (pixValid && $stable(pixData) && $stable(pixSol) && $stable(pixSof)));

  assert_sof_on_sol_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pixSof |-> (pixSol && pixValid));
endmodule

bind grey_scan_expander gse_checker #(
  .ADDR_W(ADDR_W), .ADDR_MAX(ROWS * BYTES)
) u_gse_chk (
  .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .pixReady(pixReady),
  .pixData(pixData), .pixSol(pixSol), .pixSof(pixSof),
  .memRdEn(memRdEn), .memAddr(memAddr)
);

// File: tb/grey_scan_expander_tb.sv
`timescale 1ns/1ps
module grey_scan_expander_tb;
  localparam int ROWS = 6, BYTES = 8, MAG = 4;
  localparam int ADDR_W      = $clog2(ROWS * BYTES);
  localparam int LINE_PIX    = BYTES * 2 * MAG;
  localparam int FRAME_PIX   = LINE_PIX * ROWS * MAG;
  localparam int FRAME_BYTES = ROWS * BYTES;

  logic clk = 1'b0, rst_n = 1'b0, invalidate = 1'b0, pixReady = 1'b1;
  logic [1:0] fmtSel = 2'd2;
  logic memRdEn, pixValid, pixSol, pixSof;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memRdData = 8'd0;
  logic [23:0] pixData;

  always #2 clk = ~clk;

  grey_scan_expander #(.ROWS(ROWS), .BYTES(BYTES), .MAG(MAG)) u_dut (
    .clk(clk), .rst_n(rst_n), .invalidate(invalidate), .fmtSel(fmtSel),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .pixData(pixData), .pixValid(pixValid), .pixSol(pixSol), .pixSof(pixSof),
    .pixReady(pixReady)
  );

  int errors = 0, checks = 0;
  logic [7:0] mem [FRAME_BYTES];
  int frames = 0, expIdx = 0, expAddr = 0, readsInFrame = 0, expFmt = 2;
  bit stall = 0, wasStall = 0, finished = 0;
  logic [23:0] prevPix, heldPix, expPix;
  bit heldSol, heldSof;
  logic [23:0] prevLine [LINE_PIX];
  int mx, mln, mb, mg;

  // synchronous frame memory, one cycle of read latency
  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] toRgb(input int g, input int fmt);
    int n, c;
    n = 2 * g + g / 8;
    c = g * 17;
    if (fmt == 0)      return 24'((n << 10) | (n << 5) | n);
    else if (fmt == 1) return 24'((n << 11) | ((2 * n + n / 16) << 5) | n);
    else               return 24'((c << 16) | (c << 8) | c);
  endfunction

  function automatic string fmtTag(input int fmt);
    if (fmt == 0) return "R7 555 pixel";
    if (fmt == 1) return "R8 565 pixel";
    return "R4 R6 888 pixel";
  endfunction

  // reference model, compared on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (memRdEn) begin
        check(int'(memAddr) == expAddr, "R3 read address", 24'(memAddr), 24'(expAddr));
        expAddr = (expAddr + 1) % FRAME_BYTES;
        readsInFrame++;
      end
      if (wasStall)
        check(pixValid && pixData == heldPix && pixSol == heldSol && pixSof == heldSof,
              "R10 held while stalled", pixData, heldPix);
      if (pixValid && pixReady) begin
        if (expIdx == 0) expFmt = int'(fmtSel);
        mx  = expIdx % LINE_PIX;
        mln = expIdx / LINE_PIX;
        mb  = int'(mem[(mln / MAG) * BYTES + mx / (2 * MAG)]);
        mg  = ((mx / MAG) % 2 == 1) ? mb % 16 : mb / 16;
        expPix = toRgb(mg, expFmt);
        check(pixData == expPix, fmtTag(expFmt), pixData, expPix);
        check(pixSol == (mx == 0) && pixSof == (expIdx == 0), "R11 line/frame markers",
              {22'd0, pixSol, pixSof}, {22'd0, mx == 0, expIdx == 0});
        if (mx % MAG != 0) check(pixData == prevPix, "R5 horizontal repeat", pixData, prevPix);
        if (mln % MAG != 0) check(pixData == prevLine[mx], "R5 vertical repeat", pixData, prevLine[mx]);
        prevPix = pixData;
        prevLine[mx] = pixData;
        expIdx++;
        if (expIdx == FRAME_PIX) begin
          check(readsInFrame == FRAME_BYTES, "R3 one read per byte per frame",
                24'(readsInFrame), 24'(FRAME_BYTES));
          readsInFrame = 0;
          expIdx = 0;
          frames++;
        end
      end
      wasStall = pixValid && !pixReady;
      heldPix = pixData;
      heldSol = pixSol;
      heldSof = pixSof;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1 pixReady = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  task automatic fillMem(input int seed);
    for (int i = 0; i < FRAME_BYTES; i++) mem[i] = 8'((i * 29 + seed * 71 + 3) & 255);
    mem[0] = 8'hF0;
    mem[1] = 8'h0F;
  endtask

  task automatic pulseInvalidate();
    @(posedge clk); #1 invalidate = 1'b1;
    @(posedge clk); #1 invalidate = 1'b0;
  endtask

  task automatic waitFrames(input int n);
    int target;
    target = frames + n;
    while (frames < target) @(posedge clk);
  endtask

  task automatic quietWindow(input int n, input string tag);
    bit ok;
    ok = 1;
    repeat (n) begin
      @(negedge clk);
      if (pixValid || memRdEn) ok = 0;
    end
    check(ok, tag, {22'd0, pixValid, memRdEn}, 24'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL R2 watchdog expired actual=frames %0d expected=completion", frames);
    summary();
  end

  initial begin
    int errBefore;
    fillMem(1);
    repeat (3) @(negedge clk);
    check(!pixValid && !memRdEn, "R1 quiet in reset", {22'd0, pixValid, memRdEn}, 24'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    quietWindow(50, "R1 no scan before invalidate");

    // 888 packing, no backpressure
    fmtSel = 2'd2;
    pulseInvalidate();
    waitFrames(1);
    check(frames == 1, "R2 one frame per invalidate", 24'(frames), 24'd1);
    quietWindow(100, "R12 idle after frame");

    // 555 packing under backpressure
    fillMem(2);
    stall = 1;
    fmtSel = 2'd0;
    pulseInvalidate();
    waitFrames(1);
    quietWindow(80, "R12 idle after 555 frame");

    // 565 packing under backpressure
    fillMem(3);
    fmtSel = 2'd1;
    pulseInvalidate();
    waitFrames(1);
    check(frames == 3, "R2 frame count", 24'(frames), 24'd3);
    quietWindow(80, "R12 idle after 565 frame");

    // code 3 with a format change and an invalidate in mid-frame
    fillMem(4);
    stall = 0;
    fmtSel = 2'd3;
    errBefore = errors;
    pulseInvalidate();
    while (expIdx < 200) @(posedge clk);
    #1 fmtSel = 2'd0;
    pulseInvalidate();
    waitFrames(1);
    check(errors == errBefore, "R9 format held for the running frame",
          24'(errors - errBefore), 24'd0);
    waitFrames(1);
    check(frames == 5, "R12 rescan queued by mid-frame invalidate", 24'(frames), 24'd5);
    quietWindow(120, "R12 only one queued frame");
    summary();
  end
endmodule